// File: doc/BRIEF.md
# Serial Converter Control-Byte Framing Engine

This block is the device-side digital front end of a serial successive-approximation converter. A host drives an active-low select (`cs_n`), a serial clock (`sclk`) and a data line (`din`). The engine watches `din` for the first high bit, which it takes as the start of an 8-bit control word. When the eighth bit has arrived, the engine launches a conversion. The analog part is modelled by capturing the parallel `sample_word` at the moment of launch. After one null bit period, the captured 12-bit value is shifted out on `dout`, most significant bit first.

The host may overlap framing. The start bit of the next control word is accepted once result bit 5 has left `dout`, so that conversions can follow each other every 15 serial clocks with select held low. Raising `cs_n` abandons any frame or conversion in progress and disables the data output. Low-rate `sclk`, `cs_n` and `din` are oversampled by the system clock `clk`. Every output is registered one `clk` after the serial edge that causes it.

The receive side is a three-state machine. It waits in `RX_HUNT` for a start bit. The transition `hunt->gather` is taken on an accepted start bit. It collects the seven remaining bits in `RX_GATHER`, and `gather->armed` is taken on the eighth bit. It then waits in `RX_ARMED`, and `armed->hunt` is taken on the next falling `sclk`, which emits the launch. The transmit side is a second machine. It idles in `TX_QUIET`, and `quiet->null` is taken on launch. It drives the zero bit period in `TX_NULL`, and `null->shift` is taken on the next falling edge. It walks the result in `TX_SHIFT`, and `shift->quiet` is taken after bit 0. A high `cs_n` forces `any->hunt` and `any->quiet`.

Top module: `adc_frame_engine`

## Requirements
- R1: A falling `cs_n` alone starts nothing. The first `din` bit sampled high on a rising `sclk` with `cs_n` low is the start bit and becomes `ctrl_byte[7]`. The next seven bits fill `ctrl_byte[6:0]` in arrival order. `ctrl_byte` updates only at launch.
- R2: After reset the engine is idle, and the first high `din` bit seen with `cs_n` low is accepted as a start bit.
- R3: While a conversion is pending, in its null period or shifting, a high `din` bit is ignored until result bit 5 has been driven on `dout`. After that a high bit is accepted as a new start bit.
- R4: The conversion launches on the falling `sclk` that follows the eighth control bit. `sample_word` is captured at that edge, and later changes to it have no effect on the result. `pwr_mode` equals `ctrl_byte[1:0]`, and `dout` is 0 for that bit period.
- R5: On the following falling edges `dout` carries result bits 11 down to 0, one bit per falling edge.
- R6: `done` is high for exactly one `clk` cycle, in the cycle in which bit 0 appears on `dout`.
- R7: While `cs_n` is high, `dout_oe` is 0 and `dout` is 0. Any partial control word or unfinished conversion is discarded without a `done` pulse. After `cs_n` returns low, the next high bit is a start bit.
- R8: `dout` is 0 before the first conversion after reset and after bit 0 of each result.
- R9: With `cs_n` held low, conversions can run back to back at 15 `sclk` periods each, every result intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial control data, sampled on rising `sclk` |
| sample_word | input | 12 | Stand-in for the analog value, captured at launch |
| dout | output | 1 | Serial result data, updated after falling `sclk` |
| dout_oe | output | 1 | Output enable for `dout`, low while `cs_n` is high |
| ctrl_byte | output | 8 | Last launched control word |
| pwr_mode | output | 2 | Power-mode field of the last control word |
| done | output | 1 | One-cycle pulse as the last result bit is driven |

## Verification
The assertions assume that `sclk`, `cs_n` and `din` change slowly enough that each serial level is held for at least one `clk` cycle. They also assume that `din` is stable on the cycle in which a rising `sclk` is seen. The bench keeps within this by holding each `sclk` phase for two system clocks and changing `din` together with the rising phase. The bench also changes `cs_n` only while `sclk` is low. The overlap rule is exercised with runs of high bits placed right after a control word, so that the start gate and not the data pattern decides where the next word begins.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_GATHER,
        RX_ARMED
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_QUIET,
        TX_NULL,
        TX_SHIFT
    } tx_state_t;

endpackage

// File: rtl/adc_sclk_edges.sv
module adc_sclk_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic rise,
    output logic fall
);

    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    // serial edges only count while the host selects the device
    always_comb begin
        rise = !cs_n &&  sclk && !sclk_q;
        fall = !cs_n && !sclk &&  sclk_q;
    end

endmodule

// File: rtl/adc_ctrl_rx.sv
module adc_ctrl_rx
    import adc_frame_pkg::*;
#(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              din,
    input  logic              allow_start,
    output logic              launch,
    output logic [CTRL_W-1:0] ctrl_word
);

    localparam int CNT_W = $clog2(CTRL_W + 1);

    rx_state_t         state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [CTRL_W-1:0] shreg;
    logic              take_start;

    assign take_start = (state == RX_HUNT) && rise && din && allow_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_HUNT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_HUNT:   if (take_start) nxt = RX_GATHER;
            RX_GATHER: if (rise && cnt == CNT_W'(CTRL_W - 1)) nxt = RX_ARMED;
            RX_ARMED:  if (fall) nxt = RX_HUNT;
            default:   nxt = RX_HUNT;
        endcase
        if (cs_n) nxt = RX_HUNT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (take_start) begin
            cnt   <= CNT_W'(1);
            shreg <= CTRL_W'(1);
        end else if (state == RX_GATHER && rise && !cs_n) begin
            cnt   <= cnt + CNT_W'(1);
            shreg <= {shreg[CTRL_W-2:0], din};
        end
    end

    always_comb begin
        launch    = (state == RX_ARMED) && fall;
        ctrl_word = shreg;
    end

    AST_HUNT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HUNT && rise && !allow_start) |=> state == RX_HUNT); // R3
    AST_LAUNCH_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (cnt == CNT_W'(CTRL_W) && shreg[CTRL_W-1])); // R4
    AST_RX_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (state == RX_HUNT && !launch)); // R7

endmodule

// File: rtl/adc_result_tx.sv
module adc_result_tx
    import adc_frame_pkg::*;
#(
    parameter int RES_W    = 12,
    parameter int OPEN_IDX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             fall,
    input  logic             launch,
    input  logic [RES_W-1:0] sample_word,
    output logic             dout,
    output logic             done,
    output logic             allow_start
);

    localparam int IDX_W = $clog2(RES_W);

    tx_state_t        state, nxt;
    logic [RES_W-1:0] word;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_QUIET;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_QUIET: if (launch) nxt = TX_NULL;
            TX_NULL:  if (fall) nxt = TX_SHIFT;
            TX_SHIFT: if (launch) nxt = TX_NULL;
                      else if (fall && idx == '0) nxt = TX_QUIET;
            default:  nxt = TX_QUIET;
        endcase
        if (cs_n) nxt = TX_QUIET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            idx  <= '0;
            dout <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cs_n) begin
                dout <= 1'b0;
            end else if (launch) begin
                word <= sample_word;
                dout <= 1'b0;
            end else if (fall) begin
                unique case (state)
                    TX_NULL: begin
                        dout <= word[RES_W-1];
                        idx  <= IDX_W'(RES_W - 2);
                    end
                    TX_SHIFT: begin
                        dout <= word[idx];
                        if (idx == '0) done <= 1'b1;
                        else           idx  <= idx - IDX_W'(1);
                    end
                    default: dout <= 1'b0;
                endcase
            end
        end
    end

    // next start bit may overlap the tail once bit OPEN_IDX has been driven
    always_comb begin
        allow_start = (state == TX_QUIET) ||
                      (state == TX_SHIFT && idx < IDX_W'(OPEN_IDX));
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_ENDS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> state == TX_QUIET); // R6
    AST_NULL_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (state == TX_NULL && !dout)); // R4
    AST_TX_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (state == TX_QUIET && !dout && !done)); // R7

endmodule

// File: rtl/adc_frame_engine.sv
module adc_frame_engine #(
    parameter int RES_W    = 12,
    parameter int CTRL_W   = 8,
    parameter int PD_W     = 2,
    parameter int OPEN_IDX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic [RES_W-1:0]  sample_word,
    output logic              dout,
    output logic              dout_oe,
    output logic [CTRL_W-1:0] ctrl_byte,
    output logic [PD_W-1:0]   pwr_mode,
    output logic              done
);

    logic              rise, fall, launch, allow_start;
    logic [CTRL_W-1:0] ctrl_word;

    adc_sclk_edges u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .cs_n  (cs_n),
        .rise  (rise),
        .fall  (fall)
    );

    adc_ctrl_rx #(.CTRL_W(CTRL_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .rise        (rise),
        .fall        (fall),
        .din         (din),
        .allow_start (allow_start),
        .launch      (launch),
        .ctrl_word   (ctrl_word)
    );

    adc_result_tx #(.RES_W(RES_W), .OPEN_IDX(OPEN_IDX)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .fall        (fall),
        .launch      (launch),
        .sample_word (sample_word),
        .dout        (dout),
        .done        (done),
        .allow_start (allow_start)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_byte <= '0;
            dout_oe   <= 1'b0;
        end else begin
            dout_oe <= !cs_n;
            if (launch) ctrl_byte <= ctrl_word;
        end
    end

    assign pwr_mode = ctrl_byte[PD_W-1:0];

    AST_START_BIT_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> ctrl_byte[CTRL_W-1]); // R1
    AST_OE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !dout_oe); // R7
    AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> $stable(ctrl_byte)); // R1

endmodule

// File: tb/sim_adc_frame_engine.sv
module sim_adc_frame_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic [11:0] sample_word = 12'h000;
    logic        dout, dout_oe, done;
    logic [7:0]  ctrl_byte;
    logic [1:0]  pwr_mode;

    int    n_tests = 0;
    int    n_fail = 0;
    int    n_done = 0;
    bit    started = 0;
    bit    finished = 0;
    string cur_req = "R8";

    always #2.5 clk = ~clk;

    adc_frame_engine u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .sample_word(sample_word), .dout(dout), .dout_oe(dout_oe),
        .ctrl_byte(ctrl_byte), .pwr_mode(pwr_mode), .done(done)
    );

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural reference
    bit   m_prev;
    int   m_rxn, m_rxb;
    bit   m_q[$];
    bit   e_dout, e_oe, e_done;
    int   e_ctrl;

    always @(posedge clk) begin
        e_done = 0;
        if (!rst_n) begin
            m_prev = 0; m_rxn = 0; m_rxb = 0; m_q.delete();
            e_dout = 0; e_oe = 0; e_ctrl = 0;
        end else begin
            e_oe = !cs_n;
            if (cs_n) begin
                m_rxn = 0; m_q.delete(); e_dout = 0;
            end else if (sclk && !m_prev) begin
                if (m_rxn == 0) begin
                    if (din && m_q.size() <= 5) begin m_rxn = 1; m_rxb = 1; end
                end else if (m_rxn < 8) begin
                    m_rxb = ((m_rxb << 1) | int'(din)) & 8'hFF;
                    m_rxn++;
                end
            end else if (!sclk && m_prev) begin
                if (m_rxn == 8) begin
                    e_ctrl = m_rxb; m_rxn = 0; m_q.delete();
                    for (int i = 11; i >= 0; i--) m_q.push_back(sample_word[i]);
                    e_dout = 0;
                end else if (m_q.size() > 0) begin
                    e_dout = m_q.pop_front();
                    if (m_q.size() == 0) e_done = 1;
                end else begin
                    e_dout = 0;
                end
            end
            m_prev = sclk;
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            chk({cur_req, " dout"}, int'(dout), int'(e_dout));
            chk("R7 dout_oe", int'(dout_oe), int'(e_oe));
            chk("R6 done", int'(done), int'(e_done));
            chk("R1 ctrl_byte", int'(ctrl_byte), e_ctrl);
            chk("R4 pwr_mode", int'(pwr_mode), e_ctrl & 3);
            if (done === 1'b1) n_done++;
        end
    end

    task automatic bit_out(input logic b);
        din = b; sclk = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] cb, input int total);
        for (int i = 7; i >= 0; i--) bit_out(cb[i]);
        for (int i = 8; i < total; i++) bit_out(1'b0);
    endtask

    task automatic tail();
        for (int i = 0; i < 8; i++) bit_out(1'b0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        chk("R8 reset dout", int'(dout), 0);
        chk("R7 reset oe", int'(dout_oe), 0);
        chk("R1 reset ctrl", int'(ctrl_byte), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        // R8: zeros before any conversion
        for (int i = 0; i < 5; i++) bit_out(1'b0);

        // R2: first high after reset is a start bit
        cur_req = "R2"; sample_word = 12'h9C3; d0 = n_done;
        frame(8'h9F, 16); tail();
        chk("R2 ctrl after reset", int'(ctrl_byte), 8'h9F);
        chk("R6 one done", n_done - d0, 1);

        // R5 and R4: capture at launch, later change ignored
        cur_req = "R5"; sample_word = 12'hA5C;
        for (int i = 7; i >= 0; i--) bit_out(8'hC1 >> i);
        bit_out(1'b0); bit_out(1'b0);
        sample_word = 12'h000;
        for (int i = 0; i < 14; i++) bit_out(1'b0);
        chk("R4 pwr field", int'(pwr_mode), 1);
        chk("R1 ctrl order", int'(ctrl_byte), 8'hC1);

        // R3: early high bits ignored, start accepted once bit 5 is out
        cur_req = "R3"; sample_word = 12'h3E7;
        frame(8'h83, 8);
        for (int i = 0; i < 7; i++) bit_out(1'b1);
        sample_word = 12'h5A1;
        frame(8'hC6, 16); tail();
        chk("R3 overlapped ctrl", int'(ctrl_byte), 8'hC6);

        // R9: back-to-back at 15 clocks
        cur_req = "R9"; d0 = n_done;
        sample_word = 12'h111; frame(8'h8C, 15);
        sample_word = 12'hF0F; frame(8'hAD, 15);
        sample_word = 12'h7FE; frame(8'hBE, 15);
        tail(); tail();
        chk("R9 three results", n_done - d0, 3);
        chk("R9 last ctrl", int'(ctrl_byte), 8'hBE);

        // R7: abort mid-result, then restart
        cur_req = "R7"; d0 = n_done; sample_word = 12'hFFF;
        frame(8'h9A, 12);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R7 oe low", int'(dout_oe), 0);
        chk("R7 dout low", int'(dout), 0);
        cs_n = 1'b0;
        chk("R7 no done on abort", n_done - d0, 0);
        sample_word = 12'h248;
        frame(8'hB3, 16); tail();
        chk("R7 restart ctrl", int'(ctrl_byte), 8'hB3);
        chk("R6 restart done", n_done - d0, 1);

        cur_req = "R8";
        tail();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule